// File: doc/BRIEF.md
# Control Argument Transfer Unit

This block keeps the table addresses that steer instruction fetch. It holds a current address and a future address. Each is two BCD digits with a two-digit selection group, and each digit of a group is either 0 or 9. The group of the current address decides which tables supply the next instruction line. Table 1 is always read. A second read from table 2 or table 3 can follow it, and that second line replaces the instructions read from table 1.

The block also carries out three orders. A substitution order stages a future address. An unconditional transfer jumps to a new current address. A conditional transfer adopts the staged future address when the arithmetic register is non-negative, and otherwise lets execution fall through.

Orders arrive on a valid/ready stream. `ord_ready` is low while a fetch request is outstanding. An order held on the port during that time stays pending and is taken once the fetch completes.

Fetch requests leave on a second valid/ready stream. `fetch_valid`, `fetch_addr` and `fetch_seq` hold steady until `fetch_ready` acknowledges them. The handshake completes on a clock edge where both `fetch_valid` and `fetch_ready` are high.

Top module: `ctl_arg_xfer`

## Requirements
- R1: After reset, `fetch_valid`, `flush` and `grp_err` are low, `ord_ready` is high, `fetch_addr` is 00 and the current group is 99 (`fetch_seq` = 0). The future address and future group reset to 00 and 99.
- R2: `fetch_seq` encodes the table sequence from the current group, which is held as two bits. Bit 1 is the left digit and bit 0 is the right digit, and a bit value of 1 means 9. The mapping is 2'b11 (99) gives 0 (table 1 only), 2'b01 (09) gives 1 (table 1 then table 2), and 2'b10 (90) gives 2 (table 1 then table 3).
- R3: Group 2'b00 gives `fetch_seq` = 0. It also raises `grp_err` for as long as a fetch request is up with that group.
- R4: A `line_done` pulse with no fetch outstanding raises `fetch_valid` in the next cycle, at the current address. A `line_done` pulse while a fetch is outstanding has no effect.
- R5: `fetch_valid`, `fetch_addr` and `fetch_seq` hold until `fetch_ready`. One cycle after the handshake, `fetch_valid` is low and the current address has advanced by one in BCD, with 99 wrapping to 00.
- R6: A substitution order (`ord_kind` = 1) loads the future address from `ord_digits` and the future group from `ord_grp`. It raises neither `flush` nor a fetch.
- R7: An unconditional transfer (`ord_kind` = 2) loads the current address and group from `ord_digits` and `ord_grp`. In the next cycle it gives a one-cycle `flush` pulse and raises a fetch at the new address.
- R8: A conditional transfer (`ord_kind` = 3) with `acc_neg` = 1 (minus) changes nothing: no flush, no fetch, and no change to either address.
- R9: A conditional transfer with `acc_neg` = 0 (plus) copies the future address and group into the current ones. In the next cycle it raises a one-cycle `flush` and a fetch at that address.
- R10: `ord_ready` is low while `fetch_valid` is high, and an order offered then is not consumed.
- R11: An order with `ord_kind` = 0 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ord_valid | input | 1 | Order offered |
| ord_ready | output | 1 | Order can be taken |
| ord_kind | input | 2 | 0 none, 1 substitution, 2 unconditional, 3 conditional |
| ord_digits | input | 4*DIGITS | Address digit pair of the next instruction, BCD |
| ord_grp | input | 2 | Sign-group digits of the line, 1 = 9 |
| acc_neg | input | 1 | Arithmetic register sign, 1 = minus |
| line_done | input | 1 | Instruction buffer has been consumed |
| fetch_valid | output | 1 | Fetch request up |
| fetch_ready | input | 1 | Fetch-done acknowledgement |
| fetch_addr | output | 4*DIGITS | Address to read |
| fetch_seq | output | 2 | Table sequence code |
| grp_err | output | 1 | Current group is not a legal code |
| flush | output | 1 | Clear the instruction buffer |

## Verification
The future address and group cannot be seen at any port. They only show up when a conditional transfer on plus copies them into the fetch address. That copy must also come after a substitution, with no intervening fetch stalling the order stream.

The stimulus mixes all four order kinds with a random sign and a random `fetch_ready`, so substitution followed by a later conditional transfer occurs many times. Random digit pairs are biased toward 99 so that the BCD wrap after a fetch is reached often. Directed sequences first cover each of these paths once, and also cover a `line_done` landing on an outstanding fetch.

// File: rtl/ctl_arg_pkg.sv
package ctl_arg_pkg;

  localparam int GRP_W = 2;

  typedef enum logic [1:0] {
    ORD_NONE  = 2'd0,
    ORD_SUBST = 2'd1,
    ORD_JUMP  = 2'd2,
    ORD_CJUMP = 2'd3
  } ord_kind_e;

  typedef enum logic [1:0] {
    SEQ_T1    = 2'd0,
    SEQ_T1_T2 = 2'd1,
    SEQ_T1_T3 = 2'd2,
    SEQ_RSV   = 2'd3
  } tbl_seq_e;

  localparam logic [GRP_W-1:0] GRP_99 = 2'b11;
  localparam logic [GRP_W-1:0] GRP_09 = 2'b01;
  localparam logic [GRP_W-1:0] GRP_90 = 2'b10;

endpackage

// File: rtl/cax_bcd_inc.sv
module cax_bcd_inc #(
  parameter  int DIGITS = 2,
  localparam int W      = 4 * DIGITS
) (
  input  logic [W-1:0] val,
  output logic [W-1:0] inc
);

  logic [DIGITS:0] cy;
  assign cy[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] d;
    logic       top;
    assign d   = val[4*i +: 4];
    assign top = (d >= 4'd9);
    assign inc[4*i +: 4] = !cy[i] ? d : (top ? 4'd0 : d + 4'd1);
    assign cy[i+1]       = cy[i] & top;
  end

endmodule

// File: rtl/cax_grp_decode.sv
module cax_grp_decode
  import ctl_arg_pkg::*;
(
  input  logic [GRP_W-1:0] grp,
  output tbl_seq_e         seq,
  output logic             bad
);

  always_comb begin
    bad = 1'b0;
    case (grp)
      GRP_99:  seq = SEQ_T1;
      GRP_09:  seq = SEQ_T1_T2;
      GRP_90:  seq = SEQ_T1_T3;
      default: begin
        seq = SEQ_T1;
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cax_arg_store.sv
module cax_arg_store
  import ctl_arg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  ord_kind_e         kind,
  input  logic [ADDR_W-1:0] digits,
  input  logic [GRP_W-1:0]  grp,
  input  logic              neg,
  input  logic              adv,
  input  logic [ADDR_W-1:0] adv_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [GRP_W-1:0]  cur_grp,
  output logic              launch
);

  logic [ADDR_W-1:0] fut_addr;
  logic [GRP_W-1:0]  fut_grp;

  assign launch = take && ((kind == ORD_JUMP) || (kind == ORD_CJUMP && !neg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_grp  <= GRP_99;
      fut_addr <= '0;
      fut_grp  <= GRP_99;
    end else if (adv) begin
      cur_addr <= adv_addr;
    end else if (take) begin
      case (kind)
        ORD_SUBST: begin
          fut_addr <= digits;
          fut_grp  <= grp;
        end
        ORD_JUMP: begin
          cur_addr <= digits;
          cur_grp  <= grp;
        end
        ORD_CJUMP: begin
          if (!neg) begin
            cur_addr <= fut_addr;
            cur_grp  <= fut_grp;
          end
        end
        default: ;
      endcase
    end
  end

  // R6
  subst_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == ORD_SUBST) |=> $stable(cur_addr) && $stable(cur_grp));

  // R9
  cjump_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == ORD_CJUMP && !neg) |=> cur_addr == $past(fut_addr) && cur_grp == $past(fut_grp));

endmodule

// File: rtl/ctl_arg_xfer.sv
module ctl_arg_xfer
  import ctl_arg_pkg::*;
#(
  parameter  int DIGITS = 2,
  localparam int ADDR_W = 4 * DIGITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ord_valid,
  output logic              ord_ready,
  input  logic [1:0]        ord_kind,
  input  logic [ADDR_W-1:0] ord_digits,
  input  logic [1:0]        ord_grp,
  input  logic              acc_neg,
  input  logic              line_done,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        fetch_seq,
  output logic              grp_err,
  output logic              flush
);

  logic              take;
  logic              adv;
  logic              launch;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [GRP_W-1:0]  cur_grp;
  tbl_seq_e          seq;
  logic              bad;

  assign ord_ready = !fetch_valid;
  assign take      = ord_valid && ord_ready;
  assign adv       = fetch_valid && fetch_ready;

  cax_bcd_inc #(.DIGITS(DIGITS)) u_inc (
    .val (cur_addr),
    .inc (nxt_addr)
  );

  cax_grp_decode u_dec (
    .grp (cur_grp),
    .seq (seq),
    .bad (bad)
  );

  cax_arg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .kind     (ord_kind_e'(ord_kind)),
    .digits   (ord_digits),
    .grp      (ord_grp),
    .neg      (acc_neg),
    .adv      (adv),
    .adv_addr (nxt_addr),
    .cur_addr (cur_addr),
    .cur_grp  (cur_grp),
    .launch   (launch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      flush       <= 1'b0;
    end else begin
      flush <= launch;
      if (adv)
        fetch_valid <= 1'b0;
      else if (launch || line_done)
        fetch_valid <= 1'b1;
    end
  end

  assign fetch_addr = cur_addr;
  assign fetch_seq  = seq;
  assign grp_err    = fetch_valid && bad;

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> fetch_valid && $stable(fetch_addr) && $stable(fetch_seq));

  // R5
  fetch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> !fetch_valid);

  // R7
  jump_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_valid && ord_ready && ord_kind == 2'd2) |=> flush && fetch_valid && fetch_addr == $past(ord_digits));

  // R8
  cjump_minus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_valid && ord_ready && ord_kind == 2'd3 && acc_neg) |=> !flush && $stable(fetch_addr));

  // R9
  flush_pairs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> fetch_valid && !ord_ready);

  // R3
  err_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_err |-> fetch_seq == 2'd0 && fetch_valid);

endmodule

// File: tb/ctl_arg_xfer_test.sv
module ctl_arg_xfer_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 3000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ord_valid, ord_ready;
  logic [1:0] ord_kind;
  logic [7:0] ord_digits;
  logic [1:0] ord_grp;
  logic       acc_neg, line_done;
  logic       fetch_valid, fetch_ready;
  logic [7:0] fetch_addr;
  logic [1:0] fetch_seq;
  logic       grp_err, flush;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_cur, m_fut;
  logic [1:0] m_cg, m_fg;
  logic       m_fv, m_flush;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_arg_xfer uut (
    .clk(clk), .rst_n(rst_n),
    .ord_valid(ord_valid), .ord_ready(ord_ready), .ord_kind(ord_kind),
    .ord_digits(ord_digits), .ord_grp(ord_grp), .acc_neg(acc_neg),
    .line_done(line_done), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_seq(fetch_seq), .grp_err(grp_err), .flush(flush)
  );

  function automatic logic [7:0] bcd_next(input logic [7:0] a);
    int v;
    v = (int'(a[7:4]) * 10 + int'(a[3:0]) + 1) % 100;
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [1:0] exp_seq(input logic [1:0] g);
    case (g)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R5 fetch_valid", 32'(fetch_valid), 32'(m_fv));
    chk("R5 fetch_addr", 32'(fetch_addr), 32'(m_cur));
    chk("R2 fetch_seq", 32'(fetch_seq), 32'(exp_seq(m_cg)));
    chk("R3 grp_err", 32'(grp_err), 32'(m_fv && m_cg == 2'b00));
    chk("R7 flush", 32'(flush), 32'(m_flush));
    chk("R10 ord_ready", 32'(ord_ready), 32'(!m_fv));
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] d,
                      input logic [1:0] g, input logic neg, input logic ld, input logic rdy);
    logic take, hs, launch;
    ord_valid = v; ord_kind = k; ord_digits = d; ord_grp = g;
    acc_neg = neg; line_done = ld; fetch_ready = rdy;
    take   = v && !m_fv;
    hs     = m_fv && rdy;
    launch = take && (k == 2'd2 || (k == 2'd3 && !neg));
    @(posedge clk);
    m_flush = launch;
    if (hs) begin
      m_cur = bcd_next(m_cur);
      m_fv  = 1'b0;
    end else if (take) begin
      case (k)
        2'd1: begin m_fut = d; m_fg = g; end
        2'd2: begin m_cur = d; m_cg = g; end
        2'd3: if (!neg) begin m_cur = m_fut; m_cg = m_fg; end
        default: ;
      endcase
    end
    if (!hs && (launch || ld)) m_fv = 1'b1;
    @(negedge clk);
    check_all();
  endtask

  task automatic idle(input logic rdy);
    step(1'b0, 2'd0, 8'h00, 2'b11, 1'b0, 1'b0, rdy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0;
    ord_valid = 0; ord_kind = 0; ord_digits = 0; ord_grp = 2'b11;
    acc_neg = 0; line_done = 0; fetch_ready = 0;
    m_cur = 8'h00; m_fut = 8'h00; m_cg = 2'b11; m_fg = 2'b11; m_fv = 0; m_flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 fetch_valid", 32'(fetch_valid), 0);
    chk("R1 flush", 32'(flush), 0);
    chk("R1 grp_err", 32'(grp_err), 0);
    chk("R1 ord_ready", 32'(ord_ready), 1);
    chk("R1 fetch_addr", 32'(fetch_addr), 32'h00);
    chk("R1 fetch_seq", 32'(fetch_seq), 0);

    // R6 substitution stages 42 / group 09 without fetch
    step(1, 2'd1, 8'h42, 2'b01, 0, 0, 0);
    chk("R6 no flush", 32'(flush), 0);
    chk("R6 no fetch", 32'(fetch_valid), 0);

    // R7 jump to 99 with group 90
    step(1, 2'd2, 8'h99, 2'b10, 0, 0, 0);
    chk("R7 flush", 32'(flush), 1);
    chk("R7 addr", 32'(fetch_addr), 32'h99);
    chk("R2 seq T1->T3", 32'(fetch_seq), 2);

    // R10 order offered while fetch pending is held off
    step(1, 2'd1, 8'h17, 2'b11, 0, 0, 0);
    chk("R10 ord_ready low", 32'(ord_ready), 0);
    chk("R5 addr held", 32'(fetch_addr), 32'h99);

    // R5 handshake and wrap 99 -> 00
    step(0, 2'd0, 8'h00, 2'b11, 0, 0, 1);
    chk("R5 wrap", 32'(fetch_addr), 32'h00);
    chk("R5 valid dropped", 32'(fetch_valid), 0);

    // R4 line_done raises fetch; second line_done while pending ignored
    step(0, 2'd0, 8'h00, 2'b11, 0, 1, 0);
    chk("R4 fetch raised", 32'(fetch_valid), 1);
    step(0, 2'd0, 8'h00, 2'b11, 0, 1, 0);
    step(0, 2'd0, 8'h00, 2'b11, 0, 0, 1);
    step(0, 2'd0, 8'h00, 2'b11, 0, 0, 0);
    chk("R4 no extra fetch", 32'(fetch_valid), 0);
    chk("R4 addr one step", 32'(fetch_addr), 32'h01);

    // R8 conditional on minus: nothing happens
    step(1, 2'd3, 8'h00, 2'b11, 1, 0, 0);
    chk("R8 no flush", 32'(flush), 0);
    chk("R8 no fetch", 32'(fetch_valid), 0);
    chk("R8 addr kept", 32'(fetch_addr), 32'h01);

    // R9 conditional on plus: staged 42 / 09 becomes current
    step(1, 2'd3, 8'h00, 2'b11, 0, 0, 0);
    chk("R9 flush", 32'(flush), 1);
    chk("R9 addr", 32'(fetch_addr), 32'h42);
    chk("R2 seq T1->T2", 32'(fetch_seq), 1);
    step(0, 2'd0, 8'h00, 2'b11, 0, 0, 1);

    // R11 kind 0 accepted without effect
    step(1, 2'd0, 8'h55, 2'b00, 0, 0, 0);
    chk("R11 ready", 32'(ord_ready), 1);
    chk("R11 no fetch", 32'(fetch_valid), 0);
    chk("R11 addr kept", 32'(fetch_addr), 32'h43);

    // R3 illegal group 00
    step(1, 2'd2, 8'h10, 2'b00, 0, 0, 0);
    chk("R3 grp_err", 32'(grp_err), 1);
    chk("R3 seq", 32'(fetch_seq), 0);
    step(0, 2'd0, 8'h00, 2'b11, 0, 0, 1);
    chk("R3 err cleared", 32'(grp_err), 0);

    // random mix
    for (int i = 0; i < N_RAND; i++) begin
      logic [7:0] d;
      logic [1:0] k;
      logic [1:0] g;
      if ($urandom_range(0, 3) == 0) d = 8'h99;
      else d = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      k = 2'($urandom_range(0, 3));
      g = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) g = 2'b00;
      step(1'($urandom_range(0, 1)), k, d, g, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 4) == 0), 1'($urandom_range(0, 1)));
    end
    idle(1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule